// File: doc/BRIEF.md
# Dual Data Pointer Register Bank with Auto-Toggle

This block keeps two 16-bit data pointers for an 8051-compatible core and presents exactly one of them, the active pointer, to the core's address datapath. The instruction decoder can do four things to the active pointer: write its low or high byte, load all 16 bits at once, or add one to it. The pointer that is not active never changes.

A control register holds two bits. The select bit chooses the active pointer. The toggle-enable bit makes the select bit invert by itself each time the decoder strobes the end of an instruction that used the pointer. A block copy can therefore alternate between a source pointer and a destination pointer without spending an instruction on a select write.

The inversion takes effect at the clock edge that ends the strobed instruction. The pointer access inside that same cycle still uses the old selection. A software write to the control register in that cycle takes priority over the automatic toggle.

Top module: `dual_dptr`

## Requirements
- R1: After reset, both pointers are 0x0000, the select bit is 0, the toggle-enable bit is 0, and `ctl_rdata` reads 2'b00.
- R2: `dptr` shows pointer 0 while the select bit is 0 and pointer 1 while it is 1.
- R3: A byte write with `wr_lo` replaces bits 7:0 of the active pointer with `byte_wdata`. A byte write with `wr_hi` replaces bits 15:8. When only one of the two strobes is high, the other byte keeps its value.
- R4: `load_req` replaces all 16 bits of the active pointer with `load_data`. When requests coincide, load wins over increment, and increment wins over byte writes.
- R5: `inc_req` adds one to the active pointer, and 0xFFFF wraps to 0x0000.
- R6: No request changes the pointer that is not active.
- R7: `ctl_wr` loads the select bit from `ctl_wdata[0]` and the toggle-enable bit from `ctl_wdata[1]`. `ctl_rdata` returns the current values with the same bit positions.
- R8: When toggle-enable is 1, each `instr_done` strobe inverts the select bit at that clock edge. A pointer request in the same cycle acts on the pointer that was selected before the inversion.
- R9: When toggle-enable is 0, `instr_done` has no effect on the select bit.
- R10: When `ctl_wr` and a toggling `instr_done` arrive in the same cycle, the select bit takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_wdata | input | 8 | Byte for low or high half writes |
| wr_lo | input | 1 | Write low byte of the active pointer |
| wr_hi | input | 1 | Write high byte of the active pointer |
| load_req | input | 1 | Load the full active pointer |
| load_data | input | 16 | Value for a full load |
| inc_req | input | 1 | Increment the active pointer |
| instr_done | input | 1 | Strobe marking the end of a pointer instruction |
| ctl_wr | input | 1 | Write the control register |
| ctl_wdata | input | 2 | Control value: bit 0 is select, bit 1 is toggle-enable |
| dptr | output | 16 | Active pointer |
| ctl_rdata | output | 2 | Control readback: bit 0 is select, bit 1 is toggle-enable |

## Verification
The bench drives an increment together with a toggle strobe in one cycle. A design that toggled first would increment the wrong pointer, and the copy would interleave incorrectly. It walks a pointer through 0xFFFF to check the wrap, which a carry into a wider register or a stuck high byte would break. It sends a control write on a toggling strobe, where a design that let the toggle win would leave the select bit inverted from the written value. Random mixes of coinciding requests catch a wrong priority order and any write that leaks into the pointer that is not active.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  localparam int NUM_PTR = 2;

  // Operation applied to the active pointer in one cycle.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_BYTE = 2'd3
  } ptr_op_e;

endpackage

// File: rtl/dptr_op_dec.sv
module dptr_op_dec
  import dptr_pkg::*;
(
  input  logic    load_i,
  input  logic    inc_i,
  input  logic    wr_lo_i,
  input  logic    wr_hi_i,
  output ptr_op_e op_o
);

  // Priority: full load over increment over byte writes.
  always_comb begin
    if (load_i)                op_o = OP_LOAD;
    else if (inc_i)            op_o = OP_INC;
    else if (wr_lo_i || wr_hi_i) op_o = OP_BYTE;
    else                       op_o = OP_NONE;
  end

  // R4: at most one operation class is chosen, and load always dominates.
  always_comb begin
    if (load_i) begin
      a_r4_load_first: assert (op_o == OP_LOAD);
    end
  end

endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
  import dptr_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int PTR_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  ptr_op_e           op_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic [PTR_W-1:0]  load_data_i,
  output logic [PTR_W-1:0]  ptr_o
);

  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  // Next-state
  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = sel_i && (op_i != OP_NONE);
    unique case (op_i)
      OP_LOAD: ptr_d = load_data_i;
      OP_INC:  ptr_d = ptr_q + ONE;
      OP_BYTE: begin
        if (wr_lo_i) ptr_d[BYTE_W-1:0]     = byte_data_i;
        if (wr_hi_i) ptr_d[PTR_W-1:BYTE_W] = byte_data_i;
      end
      default: ptr_d = ptr_q;
    endcase
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R5: increment steps by one and wraps at the top.
  a_r5_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && op_i == OP_INC) |=> (ptr_q == $past(ptr_q) + ONE));

  // R4: full load takes the supplied value.
  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && op_i == OP_LOAD) |=> (ptr_q == $past(load_data_i)));

  // R6: a pointer that is not active holds its value.
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i) |=> $stable(ptr_q));

  // R3: a low-only byte write leaves the high half alone.
  a_r3_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && op_i == OP_BYTE && !wr_hi_i) |=>
      (ptr_q[PTR_W-1:BYTE_W] == $past(ptr_q[PTR_W-1:BYTE_W])));

endmodule

// File: rtl/dptr_sel_ctl.sv
module dptr_sel_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr_i,
  input  logic [1:0] ctl_wdata_i,
  input  logic       instr_done_i,
  output logic       sel_o,
  output logic       tgl_en_o
);

  logic sel_q, sel_d, tgl_q, tgl_d;
  logic sel_en;

  // Next-state: software write beats the automatic toggle.
  always_comb begin
    sel_d  = sel_q;
    tgl_d  = tgl_q;
    sel_en = 1'b0;
    if (ctl_wr_i) begin
      sel_d  = ctl_wdata_i[0];
      tgl_d  = ctl_wdata_i[1];
      sel_en = 1'b1;
    end else if (instr_done_i && tgl_q) begin
      sel_d  = ~sel_q;
      sel_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      tgl_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_d;
      tgl_q <= tgl_d;
    end
  end

  assign sel_o    = sel_q;
  assign tgl_en_o = tgl_q;

  // R8: an enabled strobe without a software write inverts the select.
  a_r8_auto_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done_i && tgl_q && !ctl_wr_i) |=> (sel_q != $past(sel_q)));

  // R9: without toggle-enable or a write, the select is steady.
  a_r9_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr_i && !tgl_q) |=> $stable(sel_q));

  // R10 / R7: a software write always lands, even against a toggle.
  a_r10_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i |=> (sel_q == $past(ctl_wdata_i[0]) && tgl_q == $past(ctl_wdata_i[1])));

endmodule

// File: rtl/dual_dptr.sv
module dual_dptr
  import dptr_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int PTR_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_wdata,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              load_req,
  input  logic [PTR_W-1:0]  load_data,
  input  logic              inc_req,
  input  logic              instr_done,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wdata,
  output logic [PTR_W-1:0]  dptr,
  output logic [1:0]        ctl_rdata
);

  ptr_op_e                       op;
  logic                          sel;
  logic                          tgl_en;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptr_bus;

  dptr_op_dec u_dec (
    .load_i  (load_req),
    .inc_i   (inc_req),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .op_o    (op)
  );

  dptr_sel_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr_i     (ctl_wr),
    .ctl_wdata_i  (ctl_wdata),
    .instr_done_i (instr_done),
    .sel_o        (sel),
    .tgl_en_o     (tgl_en)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_bank
    dptr_bank #(.BYTE_W(BYTE_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_i       (sel == 1'(g)),
      .op_i        (op),
      .wr_lo_i     (wr_lo),
      .wr_hi_i     (wr_hi),
      .byte_data_i (byte_wdata),
      .load_data_i (load_data),
      .ptr_o       (ptr_bus[g])
    );
  end

  assign dptr      = ptr_bus[sel];
  assign ctl_rdata = {tgl_en, sel};

  // R1: the first cycle after reset shows a cleared pointer and control.
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (dptr == '0 && ctl_rdata == 2'b00));

endmodule

// File: tb/test_dual_dptr.sv
`timescale 1ns/1ps
module test_dual_dptr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  byte_wdata = '0;
  logic        wr_lo = 0, wr_hi = 0, load_req = 0, inc_req = 0;
  logic        instr_done = 0, ctl_wr = 0;
  logic [15:0] load_data = '0;
  logic [1:0]  ctl_wdata = '0;
  logic [15:0] dptr;
  logic [1:0]  ctl_rdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [15:0] mp [2];
  logic        msel, mten;

  always #2 clk = ~clk;

  dual_dptr i_dual_dptr (
    .clk, .rst_n, .byte_wdata, .wr_lo, .wr_hi, .load_req, .load_data,
    .inc_req, .instr_done, .ctl_wr, .ctl_wdata, .dptr, .ctl_rdata
  );

  function automatic logic [15:0] next_ptr(logic [15:0] p, logic ld, logic [15:0] ldd,
                                           logic inc, logic lo, logic hi, logic [7:0] d);
    logic [15:0] r = p;
    if (ld)       r = ldd;
    else if (inc) r = p + 16'd1;
    else begin
      if (lo) r[7:0]  = d;
      if (hi) r[15:8] = d;
    end
    return r;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (dptr !== mp[msel] || ctl_rdata !== {mten, msel}) begin
      n_bad++;
      $display("FAIL %s: dptr=%h ctl=%b expected dptr=%h ctl=%b",
               tag, dptr, ctl_rdata, mp[msel], {mten, msel});
    end
  endtask

  task automatic cyc(logic lo, logic hi, logic [7:0] d, logic ld, logic [15:0] ldd,
                     logic inc, logic cw, logic [1:0] cwd, logic done, string tag);
    wr_lo = lo; wr_hi = hi; byte_wdata = d; load_req = ld; load_data = ldd;
    inc_req = inc; ctl_wr = cw; ctl_wdata = cwd; instr_done = done;
    @(posedge clk);
    mp[msel] = next_ptr(mp[msel], ld, ldd, inc, lo, hi, d);
    if (cw) begin msel = cwd[0]; mten = cwd[1]; end
    else if (done && mten) msel = ~msel;
    #1;
    check(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: timeout actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    mp[0] = '0; mp[1] = '0; msel = 0; mten = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #0.5 check("R1");
    // R1: pointer 1 also cleared
    cyc(0,0,0,0,0,0,1,2'b01,0,"R1");
    cyc(0,0,0,0,0,0,1,2'b00,0,"R7");
    // R3 byte writes
    cyc(1,0,8'hA5,0,0,0,0,0,0,"R3");
    cyc(0,1,8'h3C,0,0,0,0,0,0,"R3");
    // R5 wrap
    cyc(0,0,0,1,16'hFFFE,0,0,0,0,"R4");
    cyc(0,0,0,0,0,1,0,0,0,"R5");
    cyc(0,0,0,0,0,1,0,0,0,"R5");
    // R4 priority
    cyc(1,1,8'h77,1,16'h1234,1,0,0,0,"R4");
    cyc(1,1,8'h77,0,0,1,0,0,0,"R4");
    // R6/R2 other pointer untouched
    cyc(0,0,0,0,0,0,1,2'b01,0,"R6");
    cyc(0,0,0,1,16'hBEEF,0,0,0,0,"R2");
    cyc(0,0,0,0,0,0,1,2'b00,0,"R6");
    // R9 no toggle when disabled
    cyc(0,0,0,0,0,1,0,0,1,"R9");
    // R8 toggle, inc acts on old selection
    cyc(0,0,0,0,0,0,1,2'b10,0,"R7");
    cyc(0,0,0,0,0,1,0,0,1,"R8");
    cyc(0,0,0,0,0,1,0,0,1,"R8");
    // R10 software write wins
    cyc(0,0,0,0,0,0,1,2'b10,1,"R10");
    cyc(0,0,0,0,0,0,1,2'b11,1,"R10");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      cyc(r[0], r[1], r[15:8], r[2] & r[3], $urandom, r[4],
          (r[7:5] == 3'd0), r[17:16], r[18], "R8");
    end
    finish_run();
  end

endmodule